// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Cache

This block caches recent virtual-page-number to physical-frame-number translations. Every entry is tagged with an address space identifier, so mappings that belong to several processes can stay resident together and a context switch needs no flush. A lookup presents a VPN and the current ASID. All valid entries are compared in parallel, and one cycle later the block answers with a hit, the frame number and the attribute bits. Otherwise it answers with a miss, which tells the requester that a page-table walk is needed.

A page walker or a privileged handler installs translations through a separate fill channel. The requester then retries the lookup. Software can invalidate the whole array, or only the non-global entries of one ASID.

Lookups use a valid/ready request stream and a valid/ready response stream. A request is taken on a cycle where `lk_valid` and `lk_ready` are both high. `lk_ready` is low only while a response is waiting and `rsp_ready` is low. A pending response holds all of its fields stable until it is consumed. The fill channel is valid/ready as well. `fill_ready` drops during any flush cycle, so a flush and a fill are never applied in the same cycle. The flush pins are plain level controls that act for one cycle each.

Top module: `xlat_cache`

## Requirements
- R1: A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. The result appears on the response outputs with `rsp_valid` high after that same edge.
- R2: A lookup hits when a valid entry has an equal VPN and either an equal ASID or its global flag set. On a hit the response returns that entry's PFN and its attribute vector. The attribute bits are 4 read, 3 write, 2 execute, 1 dirty and 0 accessed.
- R3: With no matching entry, `rsp_hit` is 0 and `rsp_pfn` and `rsp_attr` are 0. After the translation is filled, a retried lookup hits.
- R4: While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value and `lk_ready` is low. Otherwise `lk_ready` is high.
- R5: A fill is accepted on an edge where `fill_valid` and `fill_ready` are both high, and it takes one cycle. A lookup accepted on the same edge sees the contents from before the fill. Lookups accepted on later edges see the new entry.
- R6: When any entry is invalid, a fill goes to the lowest-indexed invalid entry and the round-robin pointer does not move.
- R7: When every entry is valid, a fill replaces the entry named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, after each such replacement.
- R8: `flush_all` invalidates every entry at the next edge. During any flush cycle `fill_ready` is 0.
- R9: `flush_asid_en` invalidates exactly those valid entries whose ASID equals `flush_asid` and whose global flag is clear. Global entries and entries of other ASIDs survive.
- R10: If more than one valid entry matches a lookup, the lowest-indexed one supplies the response and `rsp_multi` is 1. With one match or none, `rsp_multi` is 0.
- R11: After reset all entries are invalid and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address space identifier |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pfn | output | PFN_W | Physical frame number (0 on miss) |
| rsp_attr | output | 5 | Read, write, execute, dirty, accessed (0 on miss) |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill can be taken (low while flushing) |
| fill_vpn | input | VPN_W | VPN of the new entry |
| fill_asid | input | ASID_W | ASID of the new entry |
| fill_glob | input | 1 | New entry matches any ASID |
| fill_pfn | input | PFN_W | PFN of the new entry |
| fill_attr | input | 5 | Attribute bits of the new entry |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the non-global entries of one ASID |
| flush_asid | input | ASID_W | ASID targeted by the per-ASID flush |

## Verification
A corrupted valid bit or tag shows up one cycle after the next lookup of that page: a hit turns into a miss, a frame number comes back wrong, or `rsp_multi` rises where no duplicate was filled. A wrong victim choice or a round-robin pointer that is off by one stays hidden until the array is full. It then shows as a miss on a translation that should have survived, so the bench fills the array to capacity and probes the neighbours of each replaced entry. A fault in the back-pressure logic shows in the first stalled cycle, as a response field that changes while `rsp_ready` is low.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic dirty;
    logic accessed;
  } xlat_attr_t;

  localparam int ATTR_W = $bits(xlat_attr_t);
endpackage

// File: rtl/xlat_first.sv
// Lowest-index selector over a request vector, with a more-than-one flag.
module xlat_first #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign found = |req;
  assign multi = $countones(req) > 1;
endmodule

// File: rtl/xlat_match.sv
// Parallel tag compare of a key against every entry.
module xlat_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0]             glob,
  input  logic [N-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [N-1:0][ASID_W-1:0] asid_tab,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (vpn_tab[i] == key_vpn) &&
                        (glob[i] || (asid_tab[i] == key_asid));
  end
endmodule

// File: rtl/xlat_victim.sv
// Chooses the fill slot: lowest free entry, else a round-robin pointer.
module xlat_victim #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid,
  input  logic          advance,
  output logic [IW-1:0] slot
);
  logic          free_found;
  logic [IW-1:0] free_idx;
  logic          free_multi;
  logic [IW-1:0] rr_ptr;

  xlat_first #(.N(N)) u_free (
    .req   (~valid),
    .found (free_found),
    .idx   (free_idx),
    .multi (free_multi)
  );

  assign slot = free_found ? free_idx : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (advance && !free_found) begin
      rr_ptr <= (rr_ptr == IW'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = xlat_pkg::ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_multi,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [AW-1:0]     rsp_attr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_glob,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [AW-1:0]     fill_attr,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  import xlat_pkg::*;

  logic [N-1:0]             e_valid;
  logic [N-1:0]             e_glob;
  logic [N-1:0][VPN_W-1:0]  e_vpn;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0][PFN_W-1:0]  e_pfn;
  xlat_attr_t [N-1:0]       e_attr;

  logic          lk_fire, fill_fire, flushing;
  logic [N-1:0]  hit_vec;
  logic          sel_found, sel_multi;
  logic [IW-1:0] sel_idx, fill_slot;

  assign flushing   = flush_all || flush_asid_en;
  assign fill_ready = !flushing;
  assign fill_fire  = fill_valid && fill_ready;
  assign lk_ready   = !rsp_valid || rsp_ready;
  assign lk_fire    = lk_valid && lk_ready;

  xlat_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .valid    (e_valid),
    .glob     (e_glob),
    .vpn_tab  (e_vpn),
    .asid_tab (e_asid),
    .key_vpn  (lk_vpn),
    .key_asid (lk_asid),
    .hit_vec  (hit_vec)
  );

  xlat_first #(.N(N)) u_sel (
    .req   (hit_vec),
    .found (sel_found),
    .idx   (sel_idx),
    .multi (sel_multi)
  );

  xlat_victim #(.N(N)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (e_valid),
    .advance (fill_fire),
    .slot    (fill_slot)
  );

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic flush_hit, write_me;
    assign flush_hit = flush_asid_en && !e_glob[i] && (e_asid[i] == flush_asid);
    assign write_me  = fill_fire && (fill_slot == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_valid[i] <= 1'b0;
        e_glob[i]  <= 1'b0;
        e_vpn[i]   <= '0;
        e_asid[i]  <= '0;
        e_pfn[i]   <= '0;
        e_attr[i]  <= '0;
      end else if (flush_all) begin
        e_valid[i] <= 1'b0;
      end else if (flush_hit) begin
        e_valid[i] <= 1'b0;
      end else if (write_me) begin
        e_valid[i] <= 1'b1;
        e_glob[i]  <= fill_glob;
        e_vpn[i]   <= fill_vpn;
        e_asid[i]  <= fill_asid;
        e_pfn[i]   <= fill_pfn;
        e_attr[i]  <= xlat_attr_t'(fill_attr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pfn   <= '0;
      rsp_attr  <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= sel_found;
      rsp_multi <= sel_multi;
      rsp_pfn   <= sel_found ? e_pfn[sel_idx] : '0;
      rsp_attr  <= sel_found ? AW'(e_attr[sel_idx]) : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int PFN_W = 20,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_multi,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic [AW-1:0]    rsp_attr,
  input logic             flush_all,
  input logic             flush_asid_en,
  input logic             fill_ready
);
  assert_rsp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
      $stable(rsp_pfn) && $stable(rsp_attr) && $stable(rsp_multi)));

  assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  assert_accept_gives_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !(lk_valid && lk_ready)) |=> ((lk_valid && lk_ready) |=> !rsp_hit));

  assert_no_fill_in_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !fill_ready);

  assert_multi_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi) |-> rsp_hit);

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && rsp_attr == '0));
endmodule

bind xlat_cache xlat_cache_chk #(.PFN_W(PFN_W), .AW(AW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_ready      (lk_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_hit       (rsp_hit),
  .rsp_multi     (rsp_multi),
  .rsp_pfn       (rsp_pfn),
  .rsp_attr      (rsp_attr),
  .flush_all     (flush_all),
  .flush_asid_en (flush_asid_en),
  .fill_ready    (fill_ready)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_ready;
  logic [19:0] lk_vpn = 0;
  logic [7:0] lk_asid = 0;
  logic rsp_valid, rsp_ready = 1, rsp_hit, rsp_multi;
  logic [19:0] rsp_pfn;
  logic [4:0] rsp_attr;
  logic fill_valid = 0, fill_ready, fill_glob = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic [7:0] fill_asid = 0;
  logic [4:0] fill_attr = 0;
  logic flush_all = 0, flush_asid_en = 0;
  logic [7:0] flush_asid = 0;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic g_hit, g_multi;
  logic [19:0] g_pfn;
  logic [4:0] g_attr;

  always #5 clk = ~clk;

  xlat_cache i_xlat_cache (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] v, input logic [7:0] a);
    @(negedge clk);
    lk_vpn = v; lk_asid = a; lk_valid = 1;
    @(negedge clk);
    lk_valid = 0;
    g_hit = rsp_hit; g_multi = rsp_multi; g_pfn = rsp_pfn; g_attr = rsp_attr;
    check("R1 rsp_valid after accept", rsp_valid, 1);
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic g,
                      input logic [19:0] p, input logic [4:0] at);
    @(negedge clk);
    fill_vpn = v; fill_asid = a; fill_glob = g; fill_pfn = p; fill_attr = at; fill_valid = 1;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush_all();
    @(negedge clk);
    flush_all = 1;
    #1 check("R8 fill_ready low in flush", fill_ready, 0);
    @(negedge clk);
    flush_all = 0;
  endtask

  task automatic do_flush_asid(input logic [7:0] a);
    @(negedge clk);
    flush_asid = a; flush_asid_en = 1;
    #1 check("R8 fill_ready low in asid flush", fill_ready, 0);
    @(negedge clk);
    flush_asid_en = 0;
  endtask

  task automatic t_reset();
    check("R11 rsp_valid after reset", rsp_valid, 0);
    check("R4 lk_ready idle", lk_ready, 1);
    check("R5 fill_ready idle", fill_ready, 1);
    lookup(20'h0, 8'h0);
    check("R11 empty after reset", g_hit, 0);
  endtask

  task automatic t_basic();
    lookup(20'h12345, 8'd3);
    check("R3 miss before fill", g_hit, 0);
    check("R3 miss pfn zero", g_pfn, 0);
    fill(20'h12345, 8'd3, 0, 20'hABCDE, 5'b10110);
    lookup(20'h12345, 8'd3);
    check("R3 retry hits", g_hit, 1);
    check("R2 pfn", g_pfn, 20'hABCDE);
    check("R2 attr", g_attr, 5'b10110);
    check("R10 single no multi", g_multi, 0);
    lookup(20'h12345, 8'd4);
    check("R2 asid mismatch misses", g_hit, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_vpn = 20'h777; fill_asid = 8'd3; fill_glob = 0; fill_pfn = 20'h5; fill_attr = 5'b10000;
    fill_valid = 1; lk_vpn = 20'h777; lk_asid = 8'd3; lk_valid = 1;
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    check("R5 same-edge lookup sees old", rsp_hit, 0);
    lookup(20'h777, 8'd3);
    check("R5 next lookup sees fill", g_hit, 1);
  endtask

  task automatic t_global();
    fill(20'h4000, 8'd9, 1, 20'h11, 5'b11000);
    lookup(20'h4000, 8'd1);
    check("R2 global hits any asid", g_hit, 1);
    check("R2 global pfn", g_pfn, 20'h11);
    do_flush_asid(8'd9);
    lookup(20'h4000, 8'd1);
    check("R9 global survives asid flush", g_hit, 1);
    do_flush_asid(8'd3);
    lookup(20'h12345, 8'd3);
    check("R9 asid flush clears match", g_hit, 0);
    lookup(20'h777, 8'd3);
    check("R9 asid flush clears second", g_hit, 0);
    lookup(20'h4000, 8'd7);
    check("R9 other entry kept", g_hit, 1);
  endtask

  task automatic t_flush_all();
    do_flush_all();
    lookup(20'h4000, 8'd9);
    check("R8 flush_all clears global", g_hit, 0);
  endtask

  task automatic t_victim();
    for (int i = 0; i < 8; i++)
      fill(20'h100 + 20'(i), (i == 3) ? 8'd5 : 8'd1, 0, 20'h900 + 20'(i), 5'b10001);
    lookup(20'h107, 8'd1);
    check("R6 all slots used", g_pfn, 20'h907);
    fill(20'h200, 8'd1, 0, 20'hA00, 5'b10000);
    lookup(20'h100, 8'd1);
    check("R7 slot 0 replaced first", g_hit, 0);
    lookup(20'h200, 8'd1);
    check("R7 new entry hits", g_pfn, 20'hA00);
    fill(20'h201, 8'd1, 0, 20'hA01, 5'b10000);
    lookup(20'h101, 8'd1);
    check("R7 pointer advanced to 1", g_hit, 0);
    lookup(20'h102, 8'd1);
    check("R7 slot 2 kept", g_hit, 1);
  endtask

  task automatic t_free_first();
    do_flush_asid(8'd5);
    lookup(20'h103, 8'd5);
    check("R9 asid 5 entry gone", g_hit, 0);
    lookup(20'h104, 8'd1);
    check("R9 asid 1 entry kept", g_hit, 1);
    fill(20'h300, 8'd1, 0, 20'hB00, 5'b10000);
    lookup(20'h300, 8'd1);
    check("R6 fill into hole hits", g_pfn, 20'hB00);
    lookup(20'h102, 8'd1);
    check("R6 pointer slot untouched", g_hit, 1);
  endtask

  task automatic t_multi();
    do_flush_all();
    fill(20'h50, 8'd1, 0, 20'hA, 5'b10000);
    fill(20'h50, 8'd1, 0, 20'hB, 5'b01000);
    lookup(20'h50, 8'd1);
    check("R10 lowest index wins", g_pfn, 20'hA);
    check("R10 multi flag", g_multi, 1);
    fill(20'h51, 8'd1, 0, 20'hC, 5'b10000);
    lookup(20'h51, 8'd1);
    check("R10 no multi on single", g_multi, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 0; lk_vpn = 20'h50; lk_asid = 8'd1; lk_valid = 1;
    @(negedge clk);
    check("R1 response present", rsp_valid, 1);
    check("R4 lk_ready low when stalled", lk_ready, 0);
    lk_vpn = 20'h51;
    @(negedge clk);
    check("R4 pfn held", rsp_pfn, 20'hA);
    check("R4 valid held", rsp_valid, 1);
    rsp_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    check("R4 next request taken after release", rsp_pfn, 20'hC);
    @(negedge clk);
    check("R4 response drained", rsp_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_same_cycle();
    t_global();
    t_flush_all();
    t_victim();
    t_free_first();
    t_multi();
    t_backpressure();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule